// File: doc/BRIEF.md
# Chassis Slot Selector and Status Register Block

This block is the slot-management register set of a chassis midplane controller. Software writes a selector word that names one line-card slot and a function code. A later read of the status register returns a value whose meaning is set by that latched function code. The possible results are slot presence, presence combined with power state, a fixed power-converter health word, or the data-out bit of the slot's configuration EEPROM.

The block holds a powered flag for each slot. A selector write with function code 2 and a legal slot number sets that slot's flag, and the flag stays set until reset. Presence comes in on one input bit per slot. The supervisor's own slot number is an input, and that slot always reports as powered. A single bit-bang EEPROM port is steered to the most recently selected legal slot, and its pins reach only that slot. An identification register reports the supervisor slot.

The register port has separate write and read channels. Read data is registered and appears one cycle after the read strobe.

Top module: `slot_ctl_regs`

## Requirements
- R1: After reset all powered flags are clear, the selector reads back as 0x0000, no slot is routed (every EEPROM pin output is 0), and a status read reports the slot as absent (0x0001).
- R2: A write to offset 0x44 latches the slot number from data bits 15:12 and the function code from bits 11:8. A read of 0x44 returns {slot, function, 8'h00}.
- R3: A selector write with function code 2 and a slot number from 1 to NSLOTS sets the powered flag of that slot (slot N uses flag N-1). Later selector writes with any other function code do not clear it.
- R4: Function 0 status read at offset 0x4C: an absent slot returns 0x0001. A present slot returns 0x0002 when it is powered or equals the supervisor slot, and 0x0000 otherwise.
- R5: Function 1 status read returns 0x0001 for an absent slot and 0x0000 for a present slot.
- R6: Function 2 status read always returns 0x0008, which reports the power converter as healthy.
- R7: Function 5 status read returns the routed slot's EEPROM data-out in bit 0 when the chip-select bit is set, and 0x0000 when it is clear. Data-out of other slots has no effect.
- R8: A write to offset 0x48 holds di (bit 0), clk (bit 1) and cs (bit 3). These drive only the pins of the routed slot. All other slots' pins stay 0.
- R9: A read of offset 0x04 returns (supervisor slot << 8) | 0x80.
- R10: A selector write with slot 0, or with a slot above NSLOTS, still latches the selector. It leaves the powered flags and the EEPROM routing unchanged. Function 0 and 1 status reads of such a slot report it absent.
- R11: Function codes other than 0, 1, 2 and 5 read as 0x0000. Reads of unmapped offsets return 0xFFFF.
- R12: Read data appears with rd_valid in the cycle after rd_en. A read issued in the same cycle as a write returns the state as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | rd_data valid, one cycle after rd_en |
| slot_present | input | NSLOTS | Per-slot presence, bit N-1 for slot N |
| sup_slot | input | 4 | Slot number holding the supervisor |
| ee_clk | output | NSLOTS | Per-slot EEPROM clock |
| ee_cs | output | NSLOTS | Per-slot EEPROM chip select |
| ee_di | output | NSLOTS | Per-slot EEPROM data in |
| ee_do | input | NSLOTS | Per-slot EEPROM data out |

## Verification
The write and read channels are independent, so a selector write and a status read can land on the same clock edge. The bench provokes this by driving a function-2 selector write and a status read together while an earlier function-5 selection is active. It expects the read to return the EEPROM bit of the old selection. It then expects the power-converter word on the next read, and the newly set powered flag after switching back to function 0.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;
  localparam int DATA_W  = 16;
  localparam int FIELD_W = 4;

  // register offsets
  localparam logic [7:0] OFS_IDENT  = 8'h04;
  localparam logic [7:0] OFS_SELECT = 8'h44;
  localparam logic [7:0] OFS_EEWR   = 8'h48;
  localparam logic [7:0] OFS_STATUS = 8'h4C;

  // selector function codes
  localparam logic [FIELD_W-1:0] FN_PRESENCE = 4'd0;
  localparam logic [FIELD_W-1:0] FN_ABSENT   = 4'd1;
  localparam logic [FIELD_W-1:0] FN_POWER    = 4'd2;
  localparam logic [FIELD_W-1:0] FN_EEPROM   = 4'd5;

  // bit positions in the EEPROM write word
  localparam int EE_DI_BIT  = 0;
  localparam int EE_CLK_BIT = 1;
  localparam int EE_CS_BIT  = 3;

  localparam logic [DATA_W-1:0] STAT_ABSENT  = 16'h0001;
  localparam logic [DATA_W-1:0] STAT_PWR_OK  = 16'h0002;
  localparam logic [DATA_W-1:0] STAT_CONV_OK = 16'h0008;
  localparam logic [DATA_W-1:0] RD_UNMAPPED  = 16'hFFFF;

  typedef struct packed {
    logic cs;
    logic clk;
    logic di;
  } ee_pins_t;
endpackage

// File: rtl/slot_sel_latch.sv
module slot_sel_latch
  import slot_ctl_pkg::*;
#(
  parameter int NSLOTS = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FIELD_W-1:0] sel_slot,
  output logic [FIELD_W-1:0] sel_func,
  output logic [NSLOTS-1:0]  sel_oh,
  output logic [NSLOTS-1:0]  route_oh,
  output logic               pwr_set,
  output logic [NSLOTS-1:0]  pwr_set_oh
);
  logic [FIELD_W-1:0] new_slot;
  logic [FIELD_W-1:0] new_func;
  logic [NSLOTS-1:0]  new_oh;
  logic               new_legal;

  assign new_slot  = wdata[15:12];
  assign new_func  = wdata[11:8];
  assign new_legal = |new_oh;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_dec
    assign new_oh[i] = (new_slot == FIELD_W'(i + 1));
    assign sel_oh[i] = (sel_slot == FIELD_W'(i + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_slot <= '0;
      sel_func <= '0;
      route_oh <= '0;
    end else if (sel_we) begin
      sel_slot <= new_slot;
      sel_func <= new_func;
      if (new_legal) route_oh <= new_oh;
    end
  end

  assign pwr_set    = sel_we && new_legal && (new_func == FN_POWER);
  assign pwr_set_oh = new_oh;
endmodule

// File: rtl/slot_power_track.sv
module slot_power_track #(
  parameter int NSLOTS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [NSLOTS-1:0] set_oh,
  output logic [NSLOTS-1:0] flags
);
  for (genvar i = 0; i < NSLOTS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else if (set_en && set_oh[i]) flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/slot_ee_route.sv
module slot_ee_route
  import slot_ctl_pkg::*;
#(
  parameter int NSLOTS = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ee_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NSLOTS-1:0]  route_oh,
  input  logic [NSLOTS-1:0]  ee_do,
  output logic [NSLOTS-1:0]  ee_clk,
  output logic [NSLOTS-1:0]  ee_cs,
  output logic [NSLOTS-1:0]  ee_di,
  output logic               do_bit
);
  ee_pins_t pins_q;

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else if (ee_we) begin
      pins_q.cs  <= wdata[EE_CS_BIT];
      pins_q.clk <= wdata[EE_CLK_BIT];
      pins_q.di  <= wdata[EE_DI_BIT];
    end
  end

  for (genvar i = 0; i < NSLOTS; i++) begin : g_pin
    assign ee_clk[i] = route_oh[i] & pins_q.clk;
    assign ee_cs[i]  = route_oh[i] & pins_q.cs;
    assign ee_di[i]  = route_oh[i] & pins_q.di;
  end

  assign do_bit = pins_q.cs & (|(ee_do & route_oh));
endmodule

// File: rtl/slot_status_mux.sv
module slot_status_mux
  import slot_ctl_pkg::*;
#(
  parameter int NSLOTS = 9
) (
  input  logic [FIELD_W-1:0] sel_slot,
  input  logic [FIELD_W-1:0] sel_func,
  input  logic [NSLOTS-1:0]  sel_oh,
  input  logic [NSLOTS-1:0]  present,
  input  logic [NSLOTS-1:0]  flags,
  input  logic [FIELD_W-1:0] sup_slot,
  input  logic               do_bit,
  output logic [DATA_W-1:0]  status
);
  logic here;
  logic live;

  assign here = |(sel_oh & present);
  assign live = (|(sel_oh & flags)) || (sel_slot == sup_slot);

  always_comb begin
    status = '0;
    case (sel_func)
      FN_PRESENCE: status = !here ? STAT_ABSENT : (live ? STAT_PWR_OK : '0);
      FN_ABSENT:   status = here ? '0 : STAT_ABSENT;
      FN_POWER:    status = STAT_CONV_OK;
      FN_EEPROM:   status = {{(DATA_W-1){1'b0}}, do_bit};
      default:     status = '0;
    endcase
  end
endmodule

// File: rtl/slot_ctl_regs.sv
module slot_ctl_regs
  import slot_ctl_pkg::*;
#(
  parameter int NSLOTS = 9,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [15:0]                 wr_data,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [15:0]                 rd_data,
  output logic                        rd_valid,
  input  logic [NSLOTS-1:0]           slot_present,
  input  logic [3:0]                  sup_slot,
  output logic [NSLOTS-1:0]           ee_clk,
  output logic [NSLOTS-1:0]           ee_cs,
  output logic [NSLOTS-1:0]           ee_di,
  input  logic [NSLOTS-1:0]           ee_do
);
  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFS_IDENT);
  localparam logic [ADDR_W-1:0] A_SELECT = ADDR_W'(OFS_SELECT);
  localparam logic [ADDR_W-1:0] A_EEWR   = ADDR_W'(OFS_EEWR);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  logic [FIELD_W-1:0] sel_slot;
  logic [FIELD_W-1:0] sel_func;
  logic [NSLOTS-1:0]  sel_oh;
  logic [NSLOTS-1:0]  route_oh;
  logic               pwr_set;
  logic [NSLOTS-1:0]  pwr_set_oh;
  logic [NSLOTS-1:0]  pwr_flags;
  logic               do_bit;
  logic [DATA_W-1:0]  status;
  logic [DATA_W-1:0]  rd_next;

  slot_sel_latch #(.NSLOTS(NSLOTS)) u_sel (
    .clk(clk), .rst(rst),
    .sel_we(wr_en && (wr_addr == A_SELECT)),
    .wdata(wr_data),
    .sel_slot(sel_slot), .sel_func(sel_func), .sel_oh(sel_oh),
    .route_oh(route_oh), .pwr_set(pwr_set), .pwr_set_oh(pwr_set_oh)
  );

  slot_power_track #(.NSLOTS(NSLOTS)) u_pwr (
    .clk(clk), .rst(rst),
    .set_en(pwr_set), .set_oh(pwr_set_oh), .flags(pwr_flags)
  );

  slot_ee_route #(.NSLOTS(NSLOTS)) u_ee (
    .clk(clk), .rst(rst),
    .ee_we(wr_en && (wr_addr == A_EEWR)),
    .wdata(wr_data), .route_oh(route_oh), .ee_do(ee_do),
    .ee_clk(ee_clk), .ee_cs(ee_cs), .ee_di(ee_di), .do_bit(do_bit)
  );

  slot_status_mux #(.NSLOTS(NSLOTS)) u_stat (
    .sel_slot(sel_slot), .sel_func(sel_func), .sel_oh(sel_oh),
    .present(slot_present), .flags(pwr_flags), .sup_slot(sup_slot),
    .do_bit(do_bit), .status(status)
  );

  always_comb begin
    case (rd_addr)
      A_IDENT:  rd_next = {4'h0, sup_slot, 8'h80};
      A_SELECT: rd_next = {sel_slot, sel_func, 8'h00};
      A_STATUS: rd_next = status;
      default:  rd_next = RD_UNMAPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/slot_ctl_checker.sv
module slot_ctl_checker #(
  parameter int NSLOTS = 9,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [15:0]       rd_data,
  input logic              rd_valid,
  input logic [3:0]        sup_slot,
  input logic [NSLOTS-1:0] ee_cs,
  input logic [NSLOTS-1:0] pwr_flags,
  input logic [3:0]        sel_func
);
  logic [NSLOTS-1:0] want_oh;
  logic              sel_wr;
  logic              legal;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_w
    assign want_oh[i] = (wr_data[15:12] == 4'(i + 1));
  end
  assign sel_wr = wr_en && (wr_addr == ADDR_W'(8'h44));
  assign legal  = |want_oh;

  p_flags_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pwr_flags & $past(pwr_flags)) == $past(pwr_flags)));

  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && legal && wr_data[11:8] == 4'd2) |=>
      ((pwr_flags & $past(want_oh)) == $past(want_oh)));

  p_bad_slot_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && !legal) |=> $stable(pwr_flags));

  p_cs_single_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ee_cs));

  p_rd_latency_r12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_ident_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(8'h04)) |=>
      (rd_data == {4'h0, $past(sup_slot), 8'h80}));

  p_conv_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(8'h4C) && sel_func == 4'd2) |=>
      (rd_data == 16'h0008));
endmodule

bind slot_ctl_regs slot_ctl_checker #(.NSLOTS(NSLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .sup_slot(sup_slot), .ee_cs(ee_cs), .pwr_flags(pwr_flags), .sel_func(sel_func)
);

// File: tb/sim_slot_ctl_regs.sv
`timescale 1ns/1ps
module sim_slot_ctl_regs;
  localparam int N = 9;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [N-1:0] slot_present = 9'b1_0000_0101;
  logic [3:0]  sup_slot = 4'd1;
  logic [N-1:0] ee_clk, ee_cs, ee_di;
  logic [N-1:0] ee_do = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string req; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  slot_ctl_regs #(.NSLOTS(N), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .slot_present(slot_present), .sup_slot(sup_slot),
    .ee_clk(ee_clk), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do(ee_do)
  );

  // monitor: pops expected items as read data comes out
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R12: unexpected rd_valid, data %h expected none", rd_data);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rd_data !== it.exp) begin
          fails++;
          $display("FAIL %s: rd_data %h expected %h", it.req, rd_data, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string req);
    @(negedge clk); rd_en = 1; rd_addr = a; sb.push_back('{e, req});
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr_rd(input logic [7:0] wa, input logic [15:0] d,
                       input logic [7:0] ra, input logic [15:0] e, input string req);
    @(negedge clk); wr_en = 1; wr_addr = wa; wr_data = d;
    rd_en = 1; rd_addr = ra; sb.push_back('{e, req});
    @(negedge clk); wr_en = 0; rd_en = 0;
  endtask

  task automatic pins(input logic [N-1:0] c, input logic [N-1:0] s,
                      input logic [N-1:0] di, input string req);
    @(negedge clk);
    checks++;
    if (ee_clk !== c || ee_cs !== s || ee_di !== di) begin
      fails++;
      $display("FAIL %s: clk/cs/di %b/%b/%b expected %b/%b/%b",
               req, ee_clk, ee_cs, ee_di, c, s, di);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    pins('0, '0, '0, "R1");
    rd(8'h44, 16'h0000, "R1");
    rd(8'h4C, 16'h0001, "R1");
    // R9 identification
    rd(8'h04, 16'h0180, "R9");
    // R2 selector latch, R4 present unpowered
    wr(8'h44, 16'h3000);
    rd(8'h44, 16'h3000, "R2");
    rd(8'h4C, 16'h0000, "R4");
    // R3/R6 power up slot 3
    wr(8'h44, 16'h3200);
    rd(8'h4C, 16'h0008, "R6");
    wr(8'h44, 16'h3100);
    wr(8'h44, 16'h3000);
    rd(8'h4C, 16'h0002, "R3");
    // R4 supervisor slot and absent slot
    wr(8'h44, 16'h1000);
    rd(8'h4C, 16'h0002, "R4");
    wr(8'h44, 16'h2000);
    rd(8'h4C, 16'h0001, "R4");
    // R5
    wr(8'h44, 16'h2100);
    rd(8'h4C, 16'h0001, "R5");
    wr(8'h44, 16'h3100);
    rd(8'h4C, 16'h0000, "R5");
    // R11 unknown function and unmapped offset
    wr(8'h44, 16'h3700);
    rd(8'h4C, 16'h0000, "R11");
    rd(8'h10, 16'hFFFF, "R11");
    // R8 routing to slot 3 (last legal selection)
    wr(8'h48, 16'h000B);
    pins(9'b000000100, 9'b000000100, 9'b000000100, "R8");
    wr(8'h48, 16'h0002);
    pins(9'b000000100, 9'b000000000, 9'b000000000, "R8");
    wr(8'h48, 16'h000B);
    // R10 illegal slots keep routing and flags
    wr(8'h44, 16'h0200);
    rd(8'h44, 16'h0200, "R10");
    pins(9'b000000100, 9'b000000100, 9'b000000100, "R10");
    wr(8'h44, 16'hA200);
    pins(9'b000000100, 9'b000000100, 9'b000000100, "R10");
    wr(8'h44, 16'hA000);
    rd(8'h4C, 16'h0001, "R10");
    wr(8'h44, 16'h9000);
    rd(8'h4C, 16'h0000, "R10");
    // R7 EEPROM data out via slot 9
    wr(8'h44, 16'h9500);
    pins(9'b100000000, 9'b100000000, 9'b100000000, "R7");
    ee_do = 9'b100000000;
    rd(8'h4C, 16'h0001, "R7");
    ee_do = 9'b000000100;
    rd(8'h4C, 16'h0000, "R7");
    ee_do = 9'b100000000;
    wr(8'h48, 16'h0001);
    rd(8'h4C, 16'h0000, "R7");
    // R12 same-cycle selector write and status read
    wr(8'h48, 16'h0008);
    ee_do = '1;
    wr_rd(8'h44, 16'h9200, 8'h4C, 16'h0001, "R12");
    rd(8'h4C, 16'h0008, "R12");
    wr(8'h44, 16'h9000);
    rd(8'h4C, 16'h0002, "R12");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12: %0d reads unanswered, expected 0", sb.size());
    end
    done = 1;
    summary();
  end
endmodule